// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block generates the processor reset for a chip from three causes: an undervoltage flag from an external supply comparator, a manual reset button line that is active low, and a watchdog that the processor must service by changing the level of a strobe input. Whenever a cause is active, reset is held. When every cause has gone away, reset stays asserted for a fixed timeout and is then released. The watchdog counts only while reset is released. Either edge of the strobe clears it. It has no disable, so a strobe that never changes produces a reset pulse at a fixed period.

Both periods are counted in ticks of a prescaled enable. `TICK_DIV` sets the clock cycles per tick, `RST_TICKS` sets the reset timeout and `WD_TICKS` sets the watchdog period. The defaults give 1 ms ticks at 200 MHz, a 200 ms timeout and a 1.6 s watchdog. A testbench can shrink these to tens of cycles. The reset comes out twice: as an active-low level, and as an active-high line modelled as open drain. That second line has a data value and an output enable, and the enable is low while reset is asserted.

The controller is a three-state machine:
- `ST_HOLD`: a cause is active.
- `ST_TIMEOUT`: reset timeout running.
- `ST_RUN`: reset released, watchdog counting.

Its transitions are:
- RUN to HOLD, "cause seen".
- TIMEOUT to HOLD, "cause returns".
- HOLD to TIMEOUT, "causes clear".
- TIMEOUT to RUN, "timeout done".
- RUN to TIMEOUT, "watchdog bite".

Power-on reset places the machine in `ST_TIMEOUT`.

Top module: `sup_rstgen`

## Requirements
- R1: After power-on reset is released, the active-low reset output is 0 for exactly RST_TICKS*TICK_DIV clock cycles and then goes to 1.
- R2: While uv_flag is 1 the reset is asserted, starting the cycle after uv_flag is first sampled high. After uv_flag clears, reset stays asserted for RST_TICKS*TICK_DIV+1 further cycles.
- R3: If uv_flag returns to 1 during the reset timeout, the timeout restarts from zero once uv_flag clears again.
- R4: man_rst_n passes through a two-flop synchronizer. A low level asserts reset, even a low lasting one clock. Release follows RST_TICKS*TICK_DIV+1 cycles after the synchronized level returns high.
- R5: A rising or a falling edge of kick_i while released clears the watchdog count. Kicking more often than every WD_TICKS*TICK_DIV cycles keeps reset released.
- R6: With kick_i constant, reset is released for WD_TICKS*TICK_DIV+1 cycles and then asserted for RST_TICKS*TICK_DIV+1 cycles, repeating. The watchdog has no disable.
- R7: The watchdog count is held at zero while reset is asserted. After any release it runs a full period, however long reset was held.
- R8: rst_o is always the inverse of rst_n_o. rst_oe equals rst_n_o, so the active-high line is undriven (enable 0) exactly while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| uv_flag | input | 1 | Synchronized supply-below-threshold flag, active high |
| kick_i | input | 1 | Watchdog service strobe; any edge clears the watchdog |
| man_rst_n | input | 1 | Asynchronous manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high, data value of the open-drain line |
| rst_oe | output | 1 | Output enable of the active-high line; 0 while reset is asserted |

## Verification
The hardest situation to reach from the ports is a cause returning in the middle of the reset timeout. The machine must go back to `ST_HOLD` and later run the whole timeout again, and that is visible only as one longer reset pulse. The stimulus raises uv_flag, drops it for part of a timeout, raises it again, and expects a single low pulse whose length is the sum of the three intervals plus a full timeout.

The watchdog holding at zero during reset is reached in a similar way. A manual reset is held longer than the watchdog period while the strobe is stuck. The released interval that follows must still be the full watchdog period.

// File: rtl/sup_rstgen_pkg.sv
package sup_rstgen_pkg;

    // Controller states; the power-on state is ST_TIMEOUT
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/sup_sync.sv
// Multi-bit level synchronizer, each bit an independent asynchronous level
module sup_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], din};
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/sup_edge_det.sv
// Flags a change of a synchronized level between two consecutive samples
module sup_edge_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic chg
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= lvl;
        end
    end

    assign chg = lvl ^ prev;

endmodule

// File: rtl/sup_tick_timer.sv
// Prescaled interval timer: done rises after TICKS*DIV uncleared cycles
module sup_tick_timer #(
    parameter int DIV   = 4,
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(TICKS);

    logic          tick;
    logic [CW-1:0] cnt;

    generate
        if (DIV > 1) begin : g_pre
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
            logic [PW-1:0] pre;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre <= '0;
                end else if (clr || done) begin
                    pre <= '0;
                end else if (pre == PRE_LAST) begin
                    pre <= '0;
                end else begin
                    pre <= pre + PW'(1);
                end
            end

            assign tick = (pre == PRE_LAST);
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && !done) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = (cnt == CNT_END);

endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen
    import sup_rstgen_pkg::*;
#(
    parameter int TICK_DIV  = 200000,
    parameter int RST_TICKS = 200,
    parameter int WD_TICKS  = 1600
) (
    input  logic clk,
    input  logic por_n,
    input  logic uv_flag,
    input  logic kick_i,
    input  logic man_rst_n,
    output logic rst_n_o,
    output logic rst_o,
    output logic rst_oe
);

    sup_state_e state;
    sup_state_e nxt;

    logic kick_s;
    logic man_s_n;
    logic kick_chg;
    logic cause;
    logic tmo_clr;
    logic tmo_done;
    logic wd_clr;
    logic wd_done;

    // Asynchronous inputs: bit 1 = kick strobe, bit 0 = manual reset (idle high)
    sup_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk  (clk),
        .rst_n(por_n),
        .din  ({kick_i, man_rst_n}),
        .dout ({kick_s, man_s_n})
    );

    sup_edge_det #(
        .RST_VAL(1'b0)
    ) u_kick_edge (
        .clk  (clk),
        .rst_n(por_n),
        .lvl  (kick_s),
        .chg  (kick_chg)
    );

    // Reset timeout: runs only in ST_TIMEOUT, cleared on every entry
    assign tmo_clr = (state != ST_TIMEOUT);

    sup_tick_timer #(
        .DIV  (TICK_DIV),
        .TICKS(RST_TICKS)
    ) u_tmo (
        .clk  (clk),
        .rst_n(por_n),
        .clr  (tmo_clr),
        .done (tmo_done)
    );

    // Watchdog: held clear whenever reset is asserted or a kick edge is seen
    assign wd_clr = (state != ST_RUN) || kick_chg;

    sup_tick_timer #(
        .DIV  (TICK_DIV),
        .TICKS(WD_TICKS)
    ) u_wd (
        .clk  (clk),
        .rst_n(por_n),
        .clr  (wd_clr),
        .done (wd_done)
    );

    assign cause = uv_flag || !man_s_n;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_TIMEOUT;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (!cause) nxt = ST_TIMEOUT;      // causes clear
            end
            ST_TIMEOUT: begin
                if (cause)         nxt = ST_HOLD;  // cause returns
                else if (tmo_done) nxt = ST_RUN;   // timeout done
            end
            ST_RUN: begin
                if (cause)        nxt = ST_HOLD;    // cause seen
                else if (wd_done) nxt = ST_TIMEOUT; // watchdog bite
            end
            default: nxt = ST_TIMEOUT;
        endcase
    end

    // Outputs (Moore)
    always_comb begin
        rst_n_o = (state == ST_RUN);
        rst_o   = (state != ST_RUN);
        rst_oe  = (state == ST_RUN);
    end

endmodule

// File: rtl/sup_rstgen_chk.sv
module sup_rstgen_chk #(
    parameter int TICK_DIV  = 200000,
    parameter int RST_TICKS = 200
) (
    input logic clk,
    input logic por_n,
    input logic uv_flag,
    input logic man_rst_n,
    input logic rst_n_o,
    input logic rst_o,
    input logic rst_oe
);

    localparam logic [31:0] LOW_MIN = 32'(RST_TICKS * TICK_DIV);

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_run <= '0;
        end else if (!rst_n_o) begin
            low_run <= (low_run == 32'hFFFF_FFFF) ? low_run : low_run + 32'd1;
        end else begin
            low_run <= '0;
        end
    end

    // R1: no release before a whole timeout of asserted cycles
    assert_min_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (low_run >= LOW_MIN));

    // R2: undervoltage asserts reset on the following cycle
    assert_uv_asserts_R2: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag |=> !rst_n_o);

    // R2: release only after a cycle with the flag clear
    assert_uv_quiet_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> $past(!uv_flag));

    // R4: manual low reaches the output through two sync stages and the state
    assert_man_asserts_R4: assert property (@(posedge clk) disable iff (!por_n)
        !man_rst_n |-> ##3 !rst_n_o);

    // R8: active-high line is the inverse and undriven while asserted
    assert_inverse_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rst_o == !rst_n_o) && (rst_oe == rst_n_o));

endmodule

bind sup_rstgen sup_rstgen_chk #(
    .TICK_DIV (TICK_DIV),
    .RST_TICKS(RST_TICKS)
) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .uv_flag  (uv_flag),
    .man_rst_n(man_rst_n),
    .rst_n_o  (rst_n_o),
    .rst_o    (rst_o),
    .rst_oe   (rst_oe)
);

// File: tb/test_sup_rstgen.sv
`timescale 1ns/1ps
module test_sup_rstgen;

    localparam int D  = 4;
    localparam int RT = 10;
    localparam int WT = 30;
    localparam int RD = RT * D;   // 40
    localparam int WD = WT * D;   // 120

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic uv_flag = 1'b0;
    logic man_rst_n = 1'b1;
    logic kick_auto = 1'b0;
    logic kick_man = 1'b0;
    logic kick_en = 1'b0;
    logic kick_i;
    logic rst_n_o, rst_o, rst_oe;

    assign kick_i = kick_auto ^ kick_man;

    always #2.5 clk = ~clk;

    sup_rstgen #(.TICK_DIV(D), .RST_TICKS(RT), .WD_TICKS(WT)) i_sup_rstgen (
        .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .kick_i(kick_i),
        .man_rst_n(man_rst_n), .rst_n_o(rst_n_o), .rst_o(rst_o), .rst_oe(rst_oe)
    );

    int nchk = 0;
    int nerr = 0;

    // scoreboard of expected output runs (level, length in cycles; 0 = any)
    bit    lvl_q[$];
    int    len_q[$];
    string tag_q[$];

    task automatic push(input bit lvl, input int len, input string tag);
        lvl_q.push_back(lvl);
        len_q.push_back(len);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        while (len_q.size() != 0) @(posedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // automatic kicker: toggles every 50 cycles while enabled (R5)
    int kcnt = 0;
    always @(negedge clk) begin
        if (kick_en) begin
            kcnt++;
            if (kcnt == 50) begin
                kcnt = 0;
                #1 kick_auto = ~kick_auto;
            end
        end else begin
            kcnt = 0;
        end
    end

    // monitor: measures every run of rst_n_o and compares with the queue
    bit mon_en = 0;
    bit mon_started = 0;
    bit mon_cur;
    int mon_len;
    always @(negedge clk) begin
        if (mon_en) begin
            if (!mon_started) begin
                mon_started = 1;
                mon_cur = rst_n_o;
                mon_len = 1;
            end else if (rst_n_o == mon_cur) begin
                mon_len++;
            end else begin
                if (len_q.size() == 0) begin
                    check(1'b0, "R5 unexpected transition", mon_len, 0);
                end else begin
                    automatic bit    el = lvl_q.pop_front();
                    automatic int    ln = len_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    check(el == mon_cur, {tg, " level"}, mon_cur, el);
                    check((ln == 0) || (ln == mon_len), {tg, " run length"}, mon_len, ln);
                end
                check((rst_o == !rst_n_o) && (rst_oe == rst_n_o), "R8 inverse/enable",
                      {rst_o, rst_oe}, {!rst_n_o, rst_n_o});
                mon_cur = rst_n_o;
                mon_len = 1;
            end
        end
    end

    task automatic man_pulse(input int m);
        @(negedge clk); #1 man_rst_n = 1'b0;
        repeat (m) @(negedge clk);
        #1 man_rst_n = 1'b1;
    endtask

    task automatic uv_pulse(input int u);
        @(negedge clk); #1 uv_flag = 1'b1;
        repeat (u) @(negedge clk);
        #1 uv_flag = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    // watchdog of the bench
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R1: bench watchdog expired, actual 1 expected 0");
        finish_run();
    end

    initial begin
        // reset state (R1, R8)
        repeat (5) @(negedge clk);
        check(rst_n_o == 1'b0, "R1 reset-state rst_n_o", rst_n_o, 0);
        check(rst_oe == 1'b0, "R8 reset-state rst_oe", rst_oe, 0);
        check(rst_o == 1'b1, "R8 reset-state rst_o", rst_o, 1);

        // power-on timeout, then stuck-kick periodic pulses (R1, R6)
        push(0, RD, "R1 power-on timeout");
        push(1, WD + 1, "R6 stuck watchdog period");
        push(0, RD + 1, "R6 watchdog reset pulse");
        #1 por_n = 1'b1;
        mon_en = 1;
        drain();

        // kicking keeps reset released (R5); manual reset of 20 cycles (R4)
        kick_en = 1'b1;
        push(1, 0, "R5 kicked release");
        push(0, 20 + RD + 1, "R4 manual 20 cycles");
        man_pulse(20);
        drain();

        // single-cycle manual low is caught (R4)
        push(1, 0, "R5 kicked release");
        push(0, 1 + RD + 1, "R4 manual one cycle");
        man_pulse(1);
        drain();

        // undervoltage hold (R2)
        push(1, 0, "R5 kicked release");
        push(0, 15 + RD + 1, "R2 undervoltage 15 cycles");
        uv_pulse(15);
        drain();

        // undervoltage returns mid-timeout: restart (R3)
        push(1, 0, "R5 kicked release");
        push(0, 5 + 20 + 5 + RD + 1, "R3 timeout restart");
        uv_pulse(5);
        repeat (20) @(negedge clk);
        #1 uv_flag = 1'b1;
        repeat (5) @(negedge clk);
        #1 uv_flag = 1'b0;
        drain();

        // long manual hold with stuck kick: watchdog held clear (R7, R6)
        push(1, 0, "R5 kicked release");
        push(0, 200 + RD + 1, "R4 manual 200 cycles");
        push(1, WD + 1, "R7 full period after long hold");
        push(0, RD + 1, "R6 watchdog reset pulse");
        push(1, WD + 1, "R6 stuck watchdog period");
        push(0, RD + 1, "R6 watchdog reset pulse");
        @(negedge clk); #1 kick_en = 1'b0;
        man_pulse(200);
        drain();

        // one kick edge 100 cycles into a release postpones the bite (R5)
        push(1, WD + 104, "R5 single edge clears watchdog");
        push(0, RD + 1, "R6 watchdog reset pulse");
        repeat (100) @(negedge clk);
        #1 kick_man = ~kick_man;
        drain();

        // steady kicking: no further pulse (R5)
        kick_en = 1'b1;
        repeat (400) @(negedge clk);
        check(len_q.size() == 0, "R5 queue empty at end", len_q.size(), 0);
        check(rst_n_o == 1'b1, "R5 released while kicked", rst_n_o, 1);

        finish_run();
    end

endmodule